// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Set-Less-Than

This block is a purely combinational integer ALU of parameterised width (32 bits by default). It is assembled from a row of identical one-bit slices. Each slice evaluates a bitwise AND, a bitwise OR and a full-adder sum at the same time. A small multiplexer inside the slice then picks one of them, or a fourth input named the less input, according to the operation code. The carries ripple from slice to slice. Subtraction reuses the adder: the b operand is inverted and a carry of one is injected into the lowest slice.

A 4-bit control word selects the function. Bit 3 inverts operand a, bit 2 negates operand b (invert plus carry-in), and bits 1:0 pick the slice output. The encodings are 00 for AND, 01 for OR, 10 for the adder sum and 11 for the less input. Set-less-than feeds the sum bit of the top slice back to the less input of slice 0, and every other slice sees a constant 0 on its less input. The block also produces a zero flag, an overflow flag and the final carry-out. An equality test is a subtraction followed by a look at the zero flag.

Top module: `alu_bitslice`

## Requirements
- R1: With ctrl bits 3:2 at 00, code 00 gives result = a AND b and code 01 gives result = a OR b, bit by bit.
- R2: Control 0010 gives result = (a + b) mod 2^WIDTH.
- R3: Control 0110 gives result = (a - b) mod 2^WIDTH. The carry-in of slice 0 is 1 whenever ctrl bit 2 is 1.
- R4: When ctrl bit 3 is 1, operand a is inverted before all three units. For example, 1100 yields NOT(a OR b) and 1000 yields (NOT a) AND b.
- R5: With code 11, result bits WIDTH-1..1 are 0 and bit 0 equals the most significant sum bit of the adder under the same ctrl bits 3:2. For control 0111 this is the raw sign of a - b, with no overflow correction.
- R6: zero_o is 1 exactly when every result bit is 0, for every control value. For example, 0110 with a = b gives zero_o = 1.
- R7: ovf_o equals the XOR of the carry into the top slice and the carry out of it, for every control value.
- R8: cout_o is the carry out of the top slice. Each slice's carry-out is 1 when at least two of its adder inputs are 1.
- R9: A carry created in slice 0 travels through every slice. All-ones plus one gives result 0 with cout_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand a |
| b_i | input | WIDTH | Operand b |
| ctrl_i | input | 4 | {invert a, negate b, op[1:0]} |
| result_o | output | WIDTH | Selected slice outputs |
| zero_o | output | 1 | All result bits are 0 |
| ovf_o | output | 1 | Signed overflow of the adder |
| cout_o | output | 1 | Carry out of the top slice |

## Verification
The bench instantiates the block twice, once at the default WIDTH of 32 and once at WIDTH of 4. The 4-bit copy is small enough to sweep every operand pair under all sixteen control words. That sweep covers every overflow case, every sign outcome of set-less-than (including the overflowing ones where the raw sign is wrong) and every carry pattern. The 32-bit copy exercises the full ripple length with directed extremes, such as all-ones plus one and the most negative value compared with one, followed by a long pseudo-random run across all control words.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int CTRL_W = 4;

  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_ADD  = 2'b10,
    OP_LESS = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic    a_inv;
    logic    b_neg;
    alu_op_e op;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  logic half_x;

  assign half_x = a_i ^ b_i;
  assign s_o    = half_x ^ c_i;
  assign c_o    = (a_i & b_i) | (c_i & half_x);

  always_comb begin
    // R8
    carry_maj_chk: assert (c_o == ($countones({a_i, b_i, c_i}) >= 2))
      else $error("carry is not the majority of the adder inputs");
    // R2
    sum_par_chk: assert (s_o == (($countones({a_i, b_i, c_i}) % 2) == 1))
      else $error("sum is not the parity of the adder inputs");
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
#(
  parameter bit IS_MSB = 1'b0
) (
  input  logic      a_i,
  input  logic      b_i,
  input  alu_ctrl_t ctrl_i,
  input  logic      cin_i,
  input  logic      less_i,
  output logic      res_o,
  output logic      cout_o,
  output logic      set_o,
  output logic      ovf_o
);

  logic a_sel;
  logic b_sel;
  logic sum;

  assign a_sel = ctrl_i.a_inv ? ~a_i : a_i;
  assign b_sel = ctrl_i.b_neg ? ~b_i : b_i;

  alu_full_adder u_fa (
    .a_i (a_sel),
    .b_i (b_sel),
    .c_i (cin_i),
    .s_o (sum),
    .c_o (cout_o)
  );

  always_comb begin
    case (ctrl_i.op)
      OP_AND:  res_o = a_sel & b_sel;
      OP_OR:   res_o = a_sel | b_sel;
      OP_ADD:  res_o = sum;
      default: res_o = less_i;
    endcase
  end

  if (IS_MSB) begin : g_top
    assign set_o = sum;
    assign ovf_o = cin_i ^ cout_o;
  end else begin : g_inner
    assign set_o = 1'b0;
    assign ovf_o = 1'b0;
  end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32,
  parameter int GROUP = 8
) (
  input  logic [WIDTH-1:0] res_i,
  output logic             zero_o
);

  localparam int NGRP  = (WIDTH + GROUP - 1) / GROUP;
  localparam int PAD_W = NGRP * GROUP;

  logic [PAD_W-1:0] padded;
  logic [NGRP-1:0]  grp_any;

  assign padded = PAD_W'(res_i);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_any[g] = |padded[g*GROUP +: GROUP];
  end

  assign zero_o = ~|grp_any;

endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       ctrl_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             cout_o
);

  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] set_vec;
  logic [WIDTH-1:0] ovf_vec;
  logic             set_fb;

  assign ctrl = alu_ctrl_t'(ctrl_i);

  for (genvar i = 0; i < WIDTH; i++) begin : g_sl
    logic c_in;
    logic c_out;
    logic less;

    if (i == 0) begin : g_lsb
      assign c_in = ctrl.b_neg;
      assign less = set_fb;
    end else begin : g_up
      assign c_in = g_sl[i-1].c_out;
      assign less = 1'b0;
    end

    alu_slice #(
      .IS_MSB (i == MSB)
    ) u_slice (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .ctrl_i (ctrl),
      .cin_i  (c_in),
      .less_i (less),
      .res_o  (result_o[i]),
      .cout_o (c_out),
      .set_o  (set_vec[i]),
      .ovf_o  (ovf_vec[i])
    );
  end

  // only the top slice drives non-zero set and overflow outputs
  assign set_fb = |set_vec;
  assign ovf_o  = |ovf_vec;
  assign cout_o = g_sl[MSB].c_out;

  alu_zero_detect #(
    .WIDTH (WIDTH),
    .GROUP (8)
  ) u_zero (
    .res_i  (result_o),
    .zero_o (zero_o)
  );

  always_comb begin
    if (ctrl.op == OP_LESS) begin
      // R5
      slt_upper_chk: assert (result_o[MSB:1] == '0)
        else $error("upper result bits not clear under less code");
    end
    // R6
    zero_flag_chk: assert (zero_o == (result_o == '0))
      else $error("zero flag disagrees with result");
    if (ctrl_i == 4'b0010) begin
      // R7
      ovf_sign_chk: assert (ovf_o == ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
        else $error("overflow disagrees with operand and result signs");
      // R2
      add_sum_chk: assert ({cout_o, result_o} == ({1'b0, a_i} + {1'b0, b_i}))
        else $error("sum and carry disagree with a + b");
    end
  end

endmodule

// File: tb/tb_alu_bitslice.sv
module tb_alu_bitslice;

  localparam int W  = 32;
  localparam int WS = 4;

  logic clk;
  logic rst_n;

  logic [W-1:0]  a, b, res;
  logic [3:0]    ctrl;
  logic          zero, ovf, cout;
  logic [WS-1:0] a4, b4, res4;
  logic [3:0]    ctrl4;
  logic          zero4, ovf4, cout4;

  int n_cmp;
  int n_bad;
  bit finished;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  alu_bitslice #(.WIDTH(W)) dut (
    .a_i(a), .b_i(b), .ctrl_i(ctrl),
    .result_o(res), .zero_o(zero), .ovf_o(ovf), .cout_o(cout)
  );

  alu_bitslice #(.WIDTH(WS)) dut4 (
    .a_i(a4), .b_i(b4), .ctrl_i(ctrl4),
    .result_o(res4), .zero_o(zero4), .ovf_o(ovf4), .cout_o(cout4)
  );

  function automatic void ref_alu(input int w, input longint unsigned av,
                                  input longint unsigned bv, input logic [3:0] c,
                                  output longint unsigned r, output bit z,
                                  output bit o, output bit co);
    longint unsigned mask  = (64'd1 << w) - 1;
    longint unsigned hmask = mask >> 1;
    longint unsigned aa    = c[3] ? (~av) & mask : av & mask;
    longint unsigned bb    = c[2] ? (~bv) & mask : bv & mask;
    longint unsigned ci    = c[2] ? 64'd1 : 64'd0;
    longint unsigned sum   = aa + bb + ci;
    longint unsigned sm    = sum & mask;
    bit cm;
    co = ((sum >> w) & 1) != 0;
    cm = ((((aa & hmask) + (bb & hmask) + ci) >> (w - 1)) & 1) != 0;
    o  = cm ^ co;
    case (c[1:0])
      2'b00:   r = aa & bb;
      2'b01:   r = aa | bb;
      2'b10:   r = sm;
      default: r = (sm >> (w - 1)) & 1;
    endcase
    z = (r == 0);
  endfunction

  function automatic string res_tag(input logic [3:0] c);
    if (c[1:0] == 2'b11) return "R5";
    if (c[3]) return "R4";
    if (c[1:0] == 2'b10) return c[2] ? "R3" : "R2";
    return "R1";
  endfunction

  task automatic check(input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input int w, input longint unsigned av, input longint unsigned bv,
                         input logic [3:0] c, input string rtag,
                         input longint unsigned r_act, input bit z_act,
                         input bit o_act, input bit c_act);
    longint unsigned er;
    bit ez, eo, ec;
    ref_alu(w, av, bv, c, er, ez, eo, ec);
    check((rtag == "") ? res_tag(c) : rtag, "result", r_act, er);
    check("R6", "zero", longint'(z_act), longint'(ez));
    check("R7", "overflow", longint'(o_act), longint'(eo));
    check("R8", "carry", longint'(c_act), longint'(ec));
  endtask

  task automatic run32(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic [3:0] c, input string rtag);
    @(posedge clk);
    a <= av; b <= bv; ctrl <= c;
    @(negedge clk);
    compare(W, longint'(av), longint'(bv), c, rtag, longint'(res), zero, ovf, cout);
  endtask

  task automatic run4(input logic [WS-1:0] av, input logic [WS-1:0] bv,
                      input logic [3:0] c, input string rtag);
    @(posedge clk);
    a4 <= av; b4 <= bv; ctrl4 <= c;
    @(negedge clk);
    compare(WS, longint'(av), longint'(bv), c, rtag, longint'(res4), zero4, ovf4, cout4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    a = '0; b = '0; ctrl = 4'b0000;
    a4 = '0; b4 = '0; ctrl4 = 4'b0000;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // reset state: zero operands under AND give zero result and raised zero flag
    check("R1", "reset result", longint'(res), 0);
    check("R6", "reset zero", longint'(zero), 1);
    rst_n = 1'b1;

    // ripple corners (R9)
    run32(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010, "R9");
    run4(4'hF, 4'h1, 4'b0010, "R9");
    // signed overflow on add (R7)
    run32(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010, "");
    run32(32'h8000_0000, 32'h8000_0000, 4'b0010, "");
    // subtraction and equality (R3, R6)
    run32(32'h1234_5678, 32'h1234_5678, 4'b0110, "");
    run32(32'd5, 32'd7, 4'b0110, "");
    run32(32'd7, 32'd5, 4'b0110, "");
    run32(32'd0, 32'd1, 4'b0110, "");
    // set-less-than, raw sign without correction (R5)
    run32(32'hFFFF_FFFF, 32'd1, 4'b0111, "");
    run32(32'd1, 32'hFFFF_FFFF, 4'b0111, "");
    run32(32'h8000_0000, 32'd1, 4'b0111, "");
    run32(32'd5, 32'd5, 4'b0111, "");
    run32(32'h4000_0000, 32'h4000_0000, 4'b0011, "");
    // bitwise patterns and inverted a (R1, R4)
    run32(32'hF0F0_F0F0, 32'hFF00_FF00, 4'b0000, "");
    run32(32'hF0F0_F0F0, 32'h0F0F_0F0F, 4'b0001, "");
    run32(32'hF0F0_F0F0, 32'h0F0F_0F0F, 4'b1100, "");
    run32(32'hAAAA_5555, 32'hFFFF_0000, 4'b1000, "");
    run32(32'h0000_0000, 32'h0000_0000, 4'b1001, "");
    run32(32'h0000_0010, 32'h0000_0003, 4'b1010, "");

    // exhaustive sweep of the narrow instance
    for (int c = 0; c < 16; c++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          run4(WS'(x), WS'(y), 4'(c), "");
        end
      end
    end

    // pseudo-random wide run
    void'($urandom(32'd7));
    for (int k = 0; k < 3000; k++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      ra = $urandom;
      rb = (k % 7 == 0) ? ra : $urandom;
      run32(ra, rb, 4'(k % 16), "");
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule